// File: doc/BRIEF.md
# Signaling NaN Detect and Quiet Unit

This block inspects one or two binary32 operands and decides, for each one, whether it is a NaN and, if so, whether it is signaling or quiet. A mode input selects the polarity of the quiet bit. In legacy polarity, a set fraction MSB marks a signaling NaN. In 2008 polarity, a clear fraction MSB marks a signaling NaN.

When two operands are presented, the block picks which NaN is propagated. If the chosen word is a signaling NaN, the block returns it converted to a quiet NaN. Any signaling operand raises an invalid-operation indication for that operation. A sticky copy of that indication is held until it is cleared explicitly.

The block is meant to sit beside a floating-point datapath, which routes NaN operands through it. It has one register stage, so each accepted operation produces its result on the following cycle.

Top module: `snan_quiet_unit`

## Requirements
- R1: A word is a NaN exactly when its 8-bit exponent field (bits 30:23) is all ones and its 23-bit fraction (bits 22:0) is nonzero. Infinities and ordinary numbers are passed through unchanged with `res_nan` low.
- R2: A NaN is signaling when fraction bit 22 XOR `nan_2008` is 1. So with `nan_2008`=0 a set bit 22 means signaling, and with `nan_2008`=1 a clear bit 22 means signaling.
- R3: A quiet NaN selected as the result is returned bit for bit unchanged, and by itself it does not raise `op_invalid`.
- R4: With `nan_2008`=1, a selected signaling NaN is returned with bit 22 set, and `op_invalid` is raised.
- R5: With `nan_2008`=0, a selected signaling NaN is returned with bit 22 cleared, and `op_invalid` is raised. If clearing bit 22 leaves the fraction zero, bit 21 is set instead, so the result is still a NaN.
- R6: Quieting preserves the sign bit (bit 31), the exponent, and every fraction bit other than the quiet bit and the fix-up bit 21 case.
- R7: With `two_op`=1 and both operands NaN, the operand whose raw 23-bit fraction is larger (unsigned) is propagated. On equal fractions, `op_b` is propagated.
- R8: With `two_op`=1 and exactly one NaN, that NaN is propagated. With no NaN, `op_a` is returned. With `two_op`=0, `op_b` has no effect on any output.
- R9: With `two_op`=1, `op_invalid` is raised when either operand is a signaling NaN, including one that is not the propagated word.
- R10: `invalid_sticky` is set whenever `op_invalid` is raised and then holds until `clr_invalid` is sampled high. If a clear and a new raise fall in the same cycle, the raise wins.
- R11: `out_valid`, `result`, `res_nan` and `op_invalid` appear one cycle after the `in_valid` cycle. Synchronous `rst` clears `out_valid`, `op_invalid`, `invalid_sticky`, `res_nan` and `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| two_op | input | 1 | 1: both operands take part; 0: only op_a |
| nan_2008 | input | 1 | Quiet-bit polarity: 0 legacy, 1 2008 |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| clr_invalid | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Propagated and quieted word |
| res_nan | output | 1 | Result is a NaN |
| op_invalid | output | 1 | This operation raised invalid-operation |
| invalid_sticky | output | 1 | Accumulated invalid-operation flag |

## Verification
The sticky flag can be cleared and set in the same cycle. The bench drives `clr_invalid` high together with an operation that carries a signaling NaN, and also together with one that carries only quiet NaNs. The behavioural model predicts set-over-clear in the first case and a plain clear in the second. `invalid_sticky` is compared against that prediction on every clock, in idle cycles as well.

// File: rtl/snan_pkg.sv
package snan_pkg;
  localparam int EXP_W_DEF  = 8;
  localparam int FRAC_W_DEF = 23;

  typedef enum logic [1:0] {
    K_NUM  = 2'd0,
    K_QNAN = 2'd1,
    K_SNAN = 2'd2
  } nan_kind_e;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import snan_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              mode_2008,
  output nan_kind_e         kind
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              nan_w;

  assign expo  = word[FRAC_W +: EXP_W];
  assign frac  = word[FRAC_W-1:0];
  assign nan_w = (&expo) && (|frac);

  always_comb begin
    if (!nan_w)                           kind = K_NUM;
    else if (frac[FRAC_W-1] ^ mode_2008)  kind = K_SNAN;
    else                                  kind = K_QNAN;
  end
endmodule

// File: rtl/nan_select.sv
module nan_select
  import snan_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  nan_kind_e         kind_a,
  input  nan_kind_e         kind_b,
  input  logic              two_op,
  output logic [WORD_W-1:0] sel_word,
  output nan_kind_e         sel_kind
);
  logic a_nan, b_nan, a_wins;

  assign a_nan  = (kind_a != K_NUM);
  assign b_nan  = two_op && (kind_b != K_NUM);
  // strict compare: equal fractions go to the second operand
  assign a_wins = word_a[FRAC_W-1:0] > word_b[FRAC_W-1:0];

  always_comb begin
    sel_word = word_a;
    sel_kind = kind_a;
    if (b_nan && (!a_nan || !a_wins)) begin
      sel_word = word_b;
      sel_kind = kind_b;
    end
  end
endmodule

// File: rtl/nan_quieter.sv
module nan_quieter
  import snan_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int QB     = FRAC_W - 1,
  localparam int FB     = FRAC_W - 2
) (
  input  logic [WORD_W-1:0] word_in,
  input  nan_kind_e         kind,
  input  logic              mode_2008,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] cleared;

  always_comb begin
    cleared     = word_in;
    cleared[QB] = 1'b0;
    word_out    = word_in;
    if (kind == K_SNAN) begin
      if (mode_2008) begin
        word_out[QB] = 1'b1;
      end else begin
        word_out = cleared;
        if (cleared[FRAC_W-1:0] == '0) word_out[FB] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snan_quiet_unit.sv
module snan_quiet_unit
  import snan_pkg::*;
#(
  parameter int EXP_W  = EXP_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int N_OPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              two_op,
  input  logic              nan_2008,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              clr_invalid,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              res_nan,
  output logic              op_invalid,
  output logic              invalid_sticky
);
  logic [WORD_W-1:0] ops  [N_OPS];
  nan_kind_e         kinds[N_OPS];
  logic [WORD_W-1:0] sel_word, quiet_word;
  nan_kind_e         sel_kind;
  logic              raise;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word      (ops[i]),
      .mode_2008 (nan_2008),
      .kind      (kinds[i])
    );
  end

  nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .word_a   (op_a),
    .word_b   (op_b),
    .kind_a   (kinds[0]),
    .kind_b   (kinds[1]),
    .two_op   (two_op),
    .sel_word (sel_word),
    .sel_kind (sel_kind)
  );

  nan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .word_in   (sel_word),
    .kind      (sel_kind),
    .mode_2008 (nan_2008),
    .word_out  (quiet_word)
  );

  assign raise = (kinds[0] == K_SNAN) || (two_op && (kinds[1] == K_SNAN));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      result         <= '0;
      res_nan        <= 1'b0;
      op_invalid     <= 1'b0;
      invalid_sticky <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      op_invalid     <= in_valid && raise;
      invalid_sticky <= (invalid_sticky && !clr_invalid) || (in_valid && raise);
      if (in_valid) begin
        result  <= quiet_word;
        res_nan <= (sel_kind != K_NUM);
      end
    end
  end
endmodule

// File: rtl/snan_quiet_chk.sv
module snan_quiet_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              two_op,
  input logic              nan_2008,
  input logic [WORD_W-1:0] op_a,
  input logic              clr_invalid,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              res_nan,
  input logic              op_invalid,
  input logic              invalid_sticky
);
  AST_NAN_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_nan) |-> ((&result[FRAC_W +: EXP_W]) && (|result[FRAC_W-1:0]))); // R1
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!res_nan || (result[FRAC_W-1] == $past(nan_2008)))); // R5
  AST_QNAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !two_op && (&op_a[FRAC_W +: EXP_W]) && (|op_a[FRAC_W-1:0])
      && (op_a[FRAC_W-1] == nan_2008)) |=> (result == $past(op_a) && !op_invalid)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (invalid_sticky && !clr_invalid) |=> invalid_sticky); // R10
  AST_RAISE_STICKY: assert property (@(posedge clk) disable iff (rst)
    op_invalid |-> invalid_sticky); // R10
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !op_invalid)); // R11
endmodule

bind snan_quiet_unit snan_quiet_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .two_op         (two_op),
  .nan_2008       (nan_2008),
  .op_a           (op_a),
  .clr_invalid    (clr_invalid),
  .out_valid      (out_valid),
  .result         (result),
  .res_nan        (res_nan),
  .op_invalid     (op_invalid),
  .invalid_sticky (invalid_sticky)
);

// File: tb/test_snan_quiet_unit.sv
module test_snan_quiet_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, two_op = 1'b0, nan_2008 = 1'b0, clr_invalid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, res_nan, op_invalid, invalid_sticky;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  snan_quiet_unit i_snan_quiet_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .two_op(two_op), .nan_2008(nan_2008),
    .op_a(op_a), .op_b(op_b), .clr_invalid(clr_invalid), .out_valid(out_valid),
    .result(result), .res_nan(res_nan), .op_invalid(op_invalid),
    .invalid_sticky(invalid_sticky)
  );

  // expected state, derived from the requirements
  bit          e_valid = 0, e_nan = 0, e_inv = 0, e_sticky = 0;
  logic [31:0] e_res = '0;
  string       e_tag = "R11";

  function automatic bit is_nan(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic bit is_sig(logic [31:0] w, bit m);
    return is_nan(w) && (w[22] ^ m);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "out_valid", 32'(out_valid), 32'(e_valid));
    chk(e_tag, "op_invalid", 32'(op_invalid), 32'(e_inv));
    chk(e_tag, "invalid_sticky", 32'(invalid_sticky), 32'(e_sticky));
    if (e_valid) begin
      chk(e_tag, "result", result, e_res);
      chk(e_tag, "res_nan", 32'(res_nan), 32'(e_nan));
    end
  endtask

  task automatic step(string tag, bit v, bit two, bit m, logic [31:0] a, logic [31:0] b, bit clr);
    logic [31:0] r;
    bit raise;
    @(negedge clk);
    compare();
    in_valid = v; two_op = two; nan_2008 = m; op_a = a; op_b = b; clr_invalid = clr;
    r = a;
    if (two && is_nan(b) && (!is_nan(a) || !(a[22:0] > b[22:0]))) r = b;
    raise = is_sig(a, m) || (two && is_sig(b, m));
    if (is_sig(r, m)) begin
      if (m) r[22] = 1'b1;
      else begin
        r[22] = 1'b0;
        if (r[22:0] == 0) r[21] = 1'b1;
      end
    end
    e_tag    = tag;
    e_valid  = v;
    e_inv    = v && raise;
    e_sticky = (e_sticky && !clr) || (v && raise);
    if (v) begin
      e_res = r;
      e_nan = is_nan(r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();  // reset state, R11
    chk("R11", "reset result", result, 32'h0);
    rst = 1'b0;
    step("R5",  1, 0, 0, 32'h7FC00000, 32'h0, 0);
    step("R6",  1, 0, 0, 32'hFFC01234, 32'h0, 0);
    step("R10", 0, 0, 0, 32'h0, 32'h0, 0);
    step("R10", 0, 0, 0, 32'h0, 32'h0, 1);
    step("R3",  1, 0, 0, 32'h7F800001, 32'h0, 0);
    step("R4",  1, 0, 1, 32'h7F800001, 32'h0, 0);
    step("R2",  1, 0, 1, 32'hFFC00005, 32'h0, 1);
    step("R1",  1, 0, 0, 32'h7F800000, 32'h0, 0);
    step("R1",  1, 0, 1, 32'h3F800000, 32'h0, 0);
    step("R7",  1, 1, 0, 32'h7F800010, 32'h7F800008, 0);
    step("R7",  1, 1, 0, 32'hFF800010, 32'h7F800010, 0);
    step("R7",  1, 1, 0, 32'h7F800001, 32'h7FC00000, 0);
    step("R9",  1, 1, 1, 32'h7F800001, 32'h7FC00000, 1);
    step("R10", 1, 1, 1, 32'h7FC00001, 32'h7FC00002, 1);
    step("R8",  1, 1, 0, 32'h3F800000, 32'h7FC00000, 0);
    step("R8",  1, 1, 0, 32'h40000000, 32'h7F800000, 1);
    step("R8",  1, 0, 0, 32'h3F800000, 32'h7FC00000, 0);
    step("R6",  1, 0, 1, 32'h80801234 | 32'h7F000000, 32'h0, 0);
    step("R11", 0, 0, 0, 32'h0, 32'h0, 0);
    step("R11", 0, 0, 0, 32'h0, 32'h0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule